// File: doc/BRIEF.md
# Exception and Interrupt Control Register Block

This block holds the privileged control registers that a 32-bit processor consults when it takes exceptions and interrupts. The six registers are a faulting-address register, a free-running cycle counter, a counter match value, a status word, a cause word and a saved return address. Software reaches them through a move-to port (write) and a move-from port (read), both selected by a 5-bit register number. The control unit reports each exception through a single-cycle record strobe. That strobe carries the exception code, a branch-delay flag, the return address and the faulting address. The block answers with a combinational "take interrupt" request and a return target for the exception-return operation.

Interrupt requests collect in eight pending levels. Two are software levels written through the cause word. Five follow device request lines, sampled every cycle. One is a sticky timer level, raised when the counter reaches the match value. A pending level turns into an interrupt request only when its mask bit is set, the global enable is set and the exception-level gate is clear. Taking an exception closes the gate, and the exception-return strobe opens it again.

Top module: `sysctl_regs`

## Requirements
- R1: Register numbers 8 (faulting address), 9 (counter), 11 (match value), 12 (status), 13 (cause) and 14 (return address) are selected by `reg_sel`. `mf_rdata` shows the selected register combinationally. A move-to takes effect at the next clock edge. Any other number reads 0, and a write to it changes nothing.
- R2: Status layout: bits 15:8 are the interrupt mask (bit 8+n masks level n), bit 4 always reads 1, bit 1 is the exception-level gate, bit 0 is the global interrupt enable, and all other bits read 0. After reset the status reads 0x00000010. A move-to writes bits 15:8, 1 and 0.
- R3: Cause layout: bit 31 is the branch-delay flag, bits 15:8 are the pending levels (bit 8+n is level n), bits 6:2 are the exception code, and all other bits read 0. After reset the cause reads 0. A move-to changes only the software levels, bits 9:8.
- R4: Device line `dev_irq[k]` appears as pending level k+2 (cause bit 10+k) one clock after it is sampled, whatever the enable and mask values. The transmitter line is k=0 (cause bit 10) and the receiver line is k=1 (cause bit 11).
- R5: The counter resets to 0 and increments by 1 every clock. A move-to the counter loads the written value in place of the increment.
- R6: When counter equals match value at a clock edge, pending level 7 (cause bit 15) is set at that edge and stays set. A move-to the match value clears it at the next edge, and that clear takes priority over a match in the same cycle.
- R7: An exception record loads the code into cause bits 6:2 and `exc_bd` into cause bit 31, and sets the exception-level gate. It loads `exc_pc` into the return address only when the gate was clear before the record. When the gate was already set, the return address is kept.
- R8: The faulting-address register loads `exc_vaddr` only on an exception record with code 4 or 5. Every other code leaves it unchanged. Move-to writes never change it.
- R9: The exception-return strobe `eret` clears the exception-level gate at the next edge. `eret_target` always shows the return address register.
- R10: `take_irq` is 1 exactly when the enable bit is 1, the gate is 0 and (pending AND mask) is nonzero.
- R11: In a cycle with an exception record, a move-to the status, cause, return-address or faulting-address register is dropped, and a concurrent `eret` has no effect. An `eret` in turn overrides a move-to the status word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mt_we | input | 1 | Move-to write strobe |
| reg_sel | input | 5 | Register number for move-to and move-from |
| mt_wdata | input | 32 | Move-to write data |
| mf_rdata | output | 32 | Move-from read data of the selected register |
| exc_valid | input | 1 | Exception record strobe, one cycle per exception |
| exc_code | input | 5 | Exception code to record |
| exc_bd | input | 1 | Branch-delay flag to record |
| exc_pc | input | 32 | Return address to save |
| exc_vaddr | input | 32 | Faulting address for address-error codes |
| eret | input | 1 | Exception-return strobe |
| dev_irq | input | 5 | Device interrupt request lines, levels 2 to 6 |
| take_irq | output | 1 | Interrupt request to the control unit |
| eret_target | output | 32 | Next PC for exception return |

## Verification
The assertions take two things for granted. First, `exc_valid` and `eret` are single-cycle strobes driven by a control unit that sequences them. Second, `dev_irq` is already synchronous to `clk`. The bench drives every input one time unit after a rising edge, so each input holds for a whole cycle. It raises strobes for exactly one cycle and keeps the match value far from the counter, so the timer level rises only where a check expects it. It sweeps all 32 exception codes, every mask bit against both software levels and both enable values, and every device line. The same-cycle conflicts are driven on purpose.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int XLEN      = 32;
    localparam int SEL_W     = 5;
    localparam int N_LEVELS  = 8;
    localparam int N_SW      = 2;
    localparam int N_DEV     = 5;
    localparam int TIMER_LVL = N_LEVELS - 1;
    localparam int CODE_W    = 5;

    localparam logic [SEL_W-1:0] RN_BADV  = 5'd8;
    localparam logic [SEL_W-1:0] RN_COUNT = 5'd9;
    localparam logic [SEL_W-1:0] RN_CMP   = 5'd11;
    localparam logic [SEL_W-1:0] RN_STAT  = 5'd12;
    localparam logic [SEL_W-1:0] RN_CAUSE = 5'd13;
    localparam logic [SEL_W-1:0] RN_EPC   = 5'd14;

    localparam logic [CODE_W-1:0] EC_ADDR_LD = 5'd4;
    localparam logic [CODE_W-1:0] EC_ADDR_ST = 5'd5;

    typedef struct packed {
        logic [N_LEVELS-1:0] mask;
        logic                exl;
        logic                ie;
    } stat_t;

    typedef struct packed {
        logic                bd;
        logic [N_LEVELS-1:0] pend;
        logic [CODE_W-1:0]   code;
    } cause_t;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_EXC,
        ST_ERET,
        ST_MT
    } stat_upd_e;

    function automatic logic [XLEN-1:0] pack_stat(stat_t s);
        return {16'b0, s.mask, 3'b0, 1'b1, 2'b0, s.exl, s.ie};
    endfunction

    function automatic logic [XLEN-1:0] pack_cause(cause_t c);
        return {c.bd, 15'b0, c.pend, 1'b0, c.code, 2'b0};
    endfunction

    function automatic logic code_has_vaddr(logic [CODE_W-1:0] c);
        return (c == EC_ADDR_LD) || (c == EC_ADDR_ST);
    endfunction

endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer
    import sysctl_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_we,
    input  logic         cmp_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_o,
    output logic [W-1:0] cmp_o,
    output logic         hit_o
);
    logic [W-1:0] count_q, cmp_q;
    logic         hit_q;
    logic         match;

    assign match = (count_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cmp_q   <= '0;
            hit_q   <= 1'b0;
        end else begin
            count_q <= cnt_we ? wdata : count_q + 1'b1;
            if (cmp_we) begin
                cmp_q <= wdata;
                hit_q <= 1'b0;
            end else if (match) begin
                hit_q <= 1'b1;
            end
        end
    end

    assign count_o = count_q;
    assign cmp_o   = cmp_q;
    assign hit_o   = hit_q;
endmodule

// File: rtl/sysctl_status.sv
module sysctl_status
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_valid,
    input  logic            eret,
    input  logic            mt_we,
    input  logic [XLEN-1:0] wdata,
    output stat_t           stat_o
);
    stat_t     stat_q;
    stat_upd_e upd;

    always_comb begin
        if (exc_valid)  upd = ST_EXC;
        else if (eret)  upd = ST_ERET;
        else if (mt_we) upd = ST_MT;
        else            upd = ST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            unique case (upd)
                ST_EXC:  stat_q.exl <= 1'b1;
                ST_ERET: stat_q.exl <= 1'b0;
                ST_MT: begin
                    stat_q.mask <= wdata[8 +: N_LEVELS];
                    stat_q.exl  <= wdata[1];
                    stat_q.ie   <= wdata[0];
                end
                default: stat_q <= stat_q;
            endcase
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/sysctl_cause.sv
module sysctl_cause
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_bd,
    input  logic              mt_we,
    input  logic [N_SW-1:0]   sw_wdata,
    input  logic [N_DEV-1:0]  dev_irq,
    input  logic              timer_hit,
    output cause_t            cause_o
);
    logic              bd_q;
    logic [CODE_W-1:0] code_q;
    logic [N_SW-1:0]   sw_q;
    logic [N_DEV-1:0]  dev_q;

    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
        always_ff @(posedge clk) begin
            if (rst) dev_q[k] <= 1'b0;
            else     dev_q[k] <= dev_irq[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bd_q   <= 1'b0;
            code_q <= '0;
            sw_q   <= '0;
        end else if (exc_valid) begin
            bd_q   <= exc_bd;
            code_q <= exc_code;
        end else if (mt_we) begin
            sw_q   <= sw_wdata;
        end
    end

    assign cause_o.bd   = bd_q;
    assign cause_o.code = code_q;
    assign cause_o.pend = {timer_hit, dev_q, sw_q};
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mt_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [XLEN-1:0]   mt_wdata,
    output logic [XLEN-1:0]   mf_rdata,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_bd,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   exc_vaddr,
    input  logic              eret,
    input  logic [N_DEV-1:0]  dev_irq,
    output logic              take_irq,
    output logic [XLEN-1:0]   eret_target
);
    logic [XLEN-1:0] count_w, cmp_w, epc_q, badv_q;
    logic            timer_hit;
    stat_t           stat_w;
    cause_t          cause_w;
    logic            we_count, we_cmp, we_stat, we_cause, we_epc;

    // Move-to writes to registers the exception record owns are dropped.
    always_comb begin
        we_count = mt_we && (reg_sel == RN_COUNT);
        we_cmp   = mt_we && (reg_sel == RN_CMP);
        we_stat  = mt_we && (reg_sel == RN_STAT);
        we_cause = mt_we && (reg_sel == RN_CAUSE) && !exc_valid;
        we_epc   = mt_we && (reg_sel == RN_EPC)   && !exc_valid;
    end

    sysctl_timer #(.W(XLEN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cnt_we  (we_count),
        .cmp_we  (we_cmp),
        .wdata   (mt_wdata),
        .count_o (count_w),
        .cmp_o   (cmp_w),
        .hit_o   (timer_hit)
    );

    sysctl_status u_status (
        .clk       (clk),
        .rst       (rst),
        .exc_valid (exc_valid),
        .eret      (eret),
        .mt_we     (we_stat),
        .wdata     (mt_wdata),
        .stat_o    (stat_w)
    );

    sysctl_cause u_cause (
        .clk       (clk),
        .rst       (rst),
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .exc_bd    (exc_bd),
        .mt_we     (we_cause),
        .sw_wdata  (mt_wdata[8 +: N_SW]),
        .dev_irq   (dev_irq),
        .timer_hit (timer_hit),
        .cause_o   (cause_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q  <= '0;
            badv_q <= '0;
        end else begin
            if (exc_valid) begin
                if (!stat_w.exl)              epc_q  <= exc_pc;
                if (code_has_vaddr(exc_code)) badv_q <= exc_vaddr;
            end else if (we_epc) begin
                epc_q <= mt_wdata;
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            RN_BADV:  mf_rdata = badv_q;
            RN_COUNT: mf_rdata = count_w;
            RN_CMP:   mf_rdata = cmp_w;
            RN_STAT:  mf_rdata = pack_stat(stat_w);
            RN_CAUSE: mf_rdata = pack_cause(cause_w);
            RN_EPC:   mf_rdata = epc_q;
            default:  mf_rdata = '0;
        endcase
    end

    assign take_irq    = stat_w.ie && !stat_w.exl && |(cause_w.pend & stat_w.mask);
    assign eret_target = epc_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
    import sysctl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                mt_we,
    input logic [SEL_W-1:0]    reg_sel,
    input logic                exc_valid,
    input logic                eret,
    input logic                take_irq,
    input logic [XLEN-1:0]     count,
    input logic [XLEN-1:0]     cmp,
    input logic                timer_hit,
    input logic [N_LEVELS-1:0] pend,
    input stat_t               stat,
    input logic [XLEN-1:0]     epc,
    input logic [XLEN-1:0]     badv
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !(mt_we && reg_sel == RN_COUNT) |=> count == $past(count) + 1'b1); // R5
    AST_CMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mt_we && reg_sel == RN_CMP) |=> !timer_hit); // R6
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst)
        (count == cmp && !(mt_we && reg_sel == RN_CMP)) |=> timer_hit); // R6
    AST_EXC_GATE: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> stat.exl); // R7
    AST_NESTED_EPC: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && stat.exl) |=> $stable(epc)); // R7
    AST_BADV_RO: assert property (@(posedge clk) disable iff (rst)
        (mt_we && reg_sel == RN_BADV && !exc_valid) |=> $stable(badv)); // R8
    AST_ERET_OPENS: assert property (@(posedge clk) disable iff (rst)
        (eret && !exc_valid) |=> !stat.exl); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (pend & stat.mask) != '0); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (stat.exl || !stat.ie) |-> !take_irq); // R10
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mt_we     (mt_we),
    .reg_sel   (reg_sel),
    .exc_valid (exc_valid),
    .eret      (eret),
    .take_irq  (take_irq),
    .count     (count_w),
    .cmp       (cmp_w),
    .timer_hit (timer_hit),
    .pend      (cause_w.pend),
    .stat      (stat_w),
    .epc       (epc_q),
    .badv      (badv_q)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mt_we = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [31:0] mt_wdata = '0;
    logic [31:0] mf_rdata;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_bd = 1'b0;
    logic [31:0] exc_pc = '0;
    logic [31:0] exc_vaddr = '0;
    logic        eret = 1'b0;
    logic [4:0]  dev_irq = '0;
    logic        take_irq;
    logic [31:0] eret_target;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sysctl_regs u_dut (
        .clk(clk), .rst(rst), .mt_we(mt_we), .reg_sel(reg_sel),
        .mt_wdata(mt_wdata), .mf_rdata(mf_rdata), .exc_valid(exc_valid),
        .exc_code(exc_code), .exc_bd(exc_bd), .exc_pc(exc_pc),
        .exc_vaddr(exc_vaddr), .eret(eret), .dev_irq(dev_irq),
        .take_irq(take_irq), .eret_target(eret_target)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic mt(input logic [4:0] n, input logic [31:0] v);
        reg_sel = n; mt_wdata = v; mt_we = 1'b1;
        tick();
        mt_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] n, output logic [31:0] v);
        reg_sel = n;
        #1;
        v = mf_rdata;
    endtask

    task automatic rec(input logic [4:0] c, input logic bd,
                       input logic [31:0] pc, input logic [31:0] va);
        exc_valid = 1'b1; exc_code = c; exc_bd = bd; exc_pc = pc; exc_vaddr = va;
    endtask

    initial begin
        logic [31:0] v, bv_exp, exp;
        // reset state
        repeat (3) tick();
        rd(5'd12, v); chk("R2 status reset", v, 32'h0000_0010);
        rd(5'd13, v); chk("R3 cause reset", v, 32'h0);
        rd(5'd14, v); chk("R9 epc reset", v, 32'h0);
        rd(5'd9, v);  chk("R5 count reset", v, 32'h0);
        chk("R10 no irq at reset", {31'b0, take_irq}, 32'h0);
        rst = 1'b0;
        tick();
        rd(5'd13, v); chk("R6 match at count=cmp=0", v & 32'h8000, 32'h8000);
        mt(5'd11, 32'hFFFF_0000);
        rd(5'd13, v); chk("R6 compare write clears", v & 32'h8000, 32'h0);

        // R1 sweep over every register number (counter tested separately)
        for (int n = 0; n < 32; n++) begin
            if (n == 9) continue;
            mt(5'(n), 32'hFFFF_FFFF);
            rd(5'(n), v);
            case (n)
                8:  exp = 32'h0;
                11: exp = 32'hFFFF_FFFF;
                12: exp = 32'h0000_FF13;
                13: exp = 32'h0000_0300;
                14: exp = 32'hFFFF_FFFF;
                default: exp = 32'h0;
            endcase
            chk($sformatf("R1 R2 R3 R8 write-all-ones reg %0d", n), v, exp);
        end
        mt(5'd12, 32'h0);
        mt(5'd13, 32'h0);
        mt(5'd11, 32'hFFFF_0000);
        bv_exp = 32'h0;

        // R5 counter load and increment
        mt(5'd9, 32'd500);
        rd(5'd9, v); chk("R5 counter load", v, 32'd500);
        repeat (7) tick();
        rd(5'd9, v); chk("R5 counter +7", v, 32'd507);

        // R6 timer match timing
        mt(5'd11, 32'd600);
        mt(5'd9, 32'd597);
        repeat (3) tick();
        rd(5'd13, v); chk("R6 not yet at count 600", v & 32'h8000, 32'h0);
        tick();
        rd(5'd13, v); chk("R6 set after match", v & 32'h8000, 32'h8000);
        repeat (5) tick();
        rd(5'd13, v); chk("R6 sticky", v & 32'h8000, 32'h8000);
        mt(5'd11, 32'hFFFF_0000);
        rd(5'd13, v); chk("R6 cleared by compare write", v & 32'h8000, 32'h0);

        // R4 device lines, interrupts disabled
        for (int k = 0; k < 5; k++) begin
            dev_irq = 5'(1 << k);
            tick();
            rd(5'd13, v);
            chk($sformatf("R4 line %0d to cause bit %0d", k, 10 + k), v, 32'(1) << (10 + k));
            chk("R10 no irq while disabled", {31'b0, take_irq}, 32'h0);
        end
        dev_irq = 5'h0;
        tick();
        rd(5'd13, v); chk("R4 lines released", v, 32'h0);

        // R10 sweep: enable x mask bit x software level
        for (int ie = 0; ie < 2; ie++) begin
            for (int m = 0; m < 8; m++) begin
                for (int p = 1; p < 3; p++) begin
                    mt(5'd12, (32'(1) << (8 + m)) | 32'(ie));
                    mt(5'd13, 32'(p) << 8);
                    exp = (ie == 1 && m < 2 && ((p >> m) & 1) == 1) ? 32'h1 : 32'h0;
                    chk($sformatf("R10 ie=%0d mask=%0d sw=%0d", ie, m, p),
                        {31'b0, take_irq}, exp);
                end
            end
        end
        mt(5'd13, 32'h0);
        mt(5'd12, 32'h0000_FF01);
        dev_irq = 5'b00010;
        tick();
        chk("R4 R10 receiver line raises irq", {31'b0, take_irq}, 32'h1);
        dev_irq = 5'h0;
        mt(5'd12, 32'h0);

        // R7 R8 R9 sweep of every exception code
        for (int c = 0; c < 32; c++) begin
            rec(5'(c), c[0], 32'h1000 + 32'(c) * 4, 32'hA000 + 32'(c));
            tick();
            exc_valid = 1'b0;
            if (c == 4 || c == 5) bv_exp = 32'hA000 + 32'(c);
            rd(5'd13, v);
            chk($sformatf("R7 cause for code %0d", c), v,
                (32'(c[0]) << 31) | (32'(c) << 2));
            rd(5'd12, v); chk("R7 gate set", v, 32'h12);
            rd(5'd14, v); chk("R7 return address saved", v, 32'h1000 + 32'(c) * 4);
            rd(5'd8, v);  chk($sformatf("R8 faulting address code %0d", c), v, bv_exp);
            eret = 1'b1;
            tick();
            eret = 1'b0;
            rd(5'd12, v); chk("R9 eret clears gate", v, 32'h10);
            chk("R9 eret target", eret_target, 32'h1000 + 32'(c) * 4);
        end

        // R7 nested record keeps return address
        rec(5'd8, 1'b0, 32'h2000, 32'h0); tick();
        rec(5'd12, 1'b0, 32'h3000, 32'h0); tick();
        exc_valid = 1'b0;
        rd(5'd14, v); chk("R7 nested keeps return address", v, 32'h2000);
        rd(5'd13, v); chk("R7 nested code", v, 32'd12 << 2);
        eret = 1'b1; tick(); eret = 1'b0;

        // R11 same-cycle conflicts
        rec(5'd10, 1'b0, 32'h4000, 32'h0);
        reg_sel = 5'd14; mt_wdata = 32'hDEAD_BEEF; mt_we = 1'b1;
        tick();
        exc_valid = 1'b0; mt_we = 1'b0;
        rd(5'd14, v); chk("R11 record beats move-to return address", v, 32'h4000);
        eret = 1'b1; tick(); eret = 1'b0;

        rec(5'd9, 1'b0, 32'h5000, 32'h0);
        eret = 1'b1;
        reg_sel = 5'd12; mt_wdata = 32'h0000_FF01; mt_we = 1'b1;
        tick();
        exc_valid = 1'b0; eret = 1'b0; mt_we = 1'b0;
        rd(5'd12, v); chk("R11 record beats eret and status write", v, 32'h12);

        rec(5'd0, 1'b0, 32'h6000, 32'h0);
        reg_sel = 5'd13; mt_wdata = 32'h0000_0300; mt_we = 1'b1;
        tick();
        exc_valid = 1'b0; mt_we = 1'b0;
        rd(5'd13, v); chk("R11 record beats cause write", v, 32'h0);
        rd(5'd14, v); chk("R11 gate held, return address kept", v, 32'h5000);

        eret = 1'b1;
        reg_sel = 5'd12; mt_wdata = 32'h0000_0003; mt_we = 1'b1;
        tick();
        eret = 1'b0; mt_we = 1'b0;
        rd(5'd12, v); chk("R11 eret overrides status write", v, 32'h10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule